// File: doc/BRIEF.md
# Dual-Port Mode-Switchable Floating-Point Register File

This block holds the floating-point operand storage of a processor core: thirty-two registers of 64 bits, with two read ports and two write ports that all act in the same clock cycle. Each port carries a 5-bit register number and a precision flag. A single-precision access moves 32 bits. A double-precision access moves 64 bits. How those 64 bits map onto storage depends on one mode input, which the core drives from bit 23 of its status register.

With the mode input high ("wide mode"), every register stands alone. A single-precision access touches the low 32 bits of the named register. A double-precision access touches all 64 bits of it. With the mode input low ("paired mode"), a double-precision value spans two neighbouring registers. The even register holds the low word and the odd register after it holds the high word, each in its low 32 bits. Only even register numbers are legal for double-precision access in this mode. A double-precision access to an odd number raises an illegal-operand flag on that port, a read returns zero, and a write is dropped.

Writes land at the clock edge. A read in the same cycle sees the value being written (write-through). When both write ports hit the same 32-bit storage half in one cycle, write port 0 wins.

Top module: `fp_regfile`

## Requirements
- R1: After a synchronous active-low reset, every bit of every register reads as zero.
- R2: A single-precision access (precision flag 0) uses bits [31:0] of the named register. A read returns them on data bits [31:0], with bits [63:32] zero. A write stores data bits [31:0] and leaves bits [63:32] of that register unchanged.
- R3: In wide mode (mode input 1), a double-precision access to any register number n reads or writes all 64 bits of register n.
- R4: In paired mode (mode input 0), a double-precision access to an even n maps data bits [31:0] to bits [31:0] of register n, and data bits [63:32] to bits [31:0] of register n+1.
- R5: In paired mode, a double-precision access to an odd n does three things: it raises that port's illegal flag (the write flag only when the write is enabled), a read returns zero, and a write changes no register.
- R6: The illegal flags stay low for every other access: all accesses in wide mode, all single-precision accesses, and even-numbered double-precision accesses.
- R7: The two read ports and the two write ports act independently in the same cycle.
- R8: When both write ports write the same 32-bit storage half in one cycle, the value from write port 0 is stored.
- R9: A read in the same cycle as a write to the storage it covers returns the newly written data.
- R10: A write port with its enable low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode_i | input | 1 | 1: independent 64-bit registers; 0: even/odd pairing |
| rd0_sel_i | input | 5 | Read port 0 register number |
| rd0_dbl_i | input | 1 | Read port 0 precision (1 = double) |
| rd0_data_o | output | 64 | Read port 0 data |
| rd0_bad_o | output | 1 | Read port 0 illegal operand |
| rd1_sel_i | input | 5 | Read port 1 register number |
| rd1_dbl_i | input | 1 | Read port 1 precision (1 = double) |
| rd1_data_o | output | 64 | Read port 1 data |
| rd1_bad_o | output | 1 | Read port 1 illegal operand |
| wr0_en_i | input | 1 | Write port 0 enable |
| wr0_sel_i | input | 5 | Write port 0 register number |
| wr0_dbl_i | input | 1 | Write port 0 precision (1 = double) |
| wr0_data_i | input | 64 | Write port 0 data |
| wr0_bad_o | output | 1 | Write port 0 illegal operand |
| wr1_en_i | input | 1 | Write port 1 enable |
| wr1_sel_i | input | 5 | Write port 1 register number |
| wr1_dbl_i | input | 1 | Write port 1 precision (1 = double) |
| wr1_data_i | input | 64 | Write port 1 data |
| wr1_bad_o | output | 1 | Write port 1 illegal operand |

## Verification
The bench targets several corner cases.
- A single-precision write that clobbers the upper word would show up on a later wide-mode read.
- A pair write aimed at an odd register would corrupt two registers instead of raising the flag.
- A priority flaw between write ports shows up when port 0 writes register 11 single-precision while port 1 writes the 10/11 pair: only register 11's word must come from port 0, and register 10's word must come from port 1.
- Missing write-through shows up as stale data on same-cycle reads.
- Long random runs with the mode flipping every cycle catch a mode decode that uses the wrong register half.

// File: rtl/fpr_pkg.sv
// Package: shared constants and access classification for the FP register file.
// Assumes register numbers are binary and that pairing uses bit 0 of the number.
package fpr_pkg;

    localparam int unsigned FPR_NREG = 32;
    localparam int unsigned FPR_HALF = 32;

    // How one access maps onto storage halves.
    typedef enum logic [1:0] {
        ACC_LOW  = 2'd0,   // single precision: low half of one register
        ACC_WIDE = 2'd1,   // wide-mode double: both halves of one register
        ACC_PAIR = 2'd2,   // paired-mode double: low halves of n and n+1
        ACC_BAD  = 2'd3    // paired-mode double on an odd number
    } acc_kind_t;

    // Decide the access kind from precision, mode and the number's low bit.
    function automatic acc_kind_t fpr_classify(input logic dbl, input logic wide,
                                               input logic sel_lsb);
        if (!dbl)   return ACC_LOW;
        if (wide)   return ACC_WIDE;
        if (sel_lsb) return ACC_BAD;
        return ACC_PAIR;
    endfunction

endpackage

// File: rtl/fpr_wr_decode.sv
// Module: one write port's decoder. It turns register number, precision and
// mode into per-register, per-half write enables and values.
// Assumes the caller merges ports by priority; this module sees only its own port.
module fpr_wr_decode
    import fpr_pkg::*;
#(
    parameter int unsigned NREG = FPR_NREG,
    parameter int unsigned HALF = FPR_HALF,
    localparam int unsigned SELW = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wide_mode_i,
    input  logic                       en_i,
    input  logic [SELW-1:0]            sel_i,
    input  logic                       dbl_i,
    input  logic [2*HALF-1:0]          data_i,
    output logic [NREG-1:0]            lo_we_o,
    output logic [NREG-1:0]            hi_we_o,
    output logic [NREG-1:0][HALF-1:0]  lo_val_o,
    output logic [HALF-1:0]            hi_val_o,
    output logic                       bad_o
);

    acc_kind_t       kind;
    logic [SELW-1:0] sel_odd;

    // Classify this port's access and find the odd partner of the named register.
    always_comb begin
        kind    = fpr_classify(dbl_i, wide_mode_i, sel_i[0]);
        sel_odd = sel_i | SELW'(1);
    end

    assign bad_o    = en_i && (kind == ACC_BAD);
    assign hi_val_o = data_i[2*HALF-1:HALF];

    for (genvar n = 0; n < NREG; n++) begin : g_reg
        // Work out whether and what this port writes into register n's halves.
        always_comb begin
            lo_we_o[n]  = 1'b0;
            hi_we_o[n]  = 1'b0;
            lo_val_o[n] = data_i[HALF-1:0];
            if (en_i) begin
                unique case (kind)
                    ACC_LOW: begin
                        lo_we_o[n] = (sel_i == SELW'(n));
                    end
                    ACC_WIDE: begin
                        lo_we_o[n] = (sel_i == SELW'(n));
                        hi_we_o[n] = (sel_i == SELW'(n));
                    end
                    ACC_PAIR: begin
                        if (sel_i == SELW'(n)) begin
                            lo_we_o[n] = 1'b1;
                        end else if (sel_odd == SELW'(n)) begin
                            lo_we_o[n]  = 1'b1;
                            lo_val_o[n] = data_i[2*HALF-1:HALF];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: an odd pair write must not enable any storage half.
    p_odd_pair_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !wide_mode_i && dbl_i && sel_i[0]) |-> (lo_we_o == '0 && hi_we_o == '0));

    // R2: a single-precision write never touches an upper half.
    p_single_keeps_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !dbl_i) |-> (hi_we_o == '0));

endmodule

// File: rtl/fpr_store.sv
// Module: the storage array. It merges two decoded write ports, with port A
// ahead of port B, and exposes the next-state values so reads see writes at once.
// Assumes the decoders already suppressed illegal writes.
module fpr_store #(
    parameter int unsigned NREG = 32,
    parameter int unsigned HALF = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NREG-1:0]            a_lo_we_i,
    input  logic [NREG-1:0]            a_hi_we_i,
    input  logic [NREG-1:0][HALF-1:0]  a_lo_val_i,
    input  logic [HALF-1:0]            a_hi_val_i,
    input  logic [NREG-1:0]            b_lo_we_i,
    input  logic [NREG-1:0]            b_hi_we_i,
    input  logic [NREG-1:0][HALF-1:0]  b_lo_val_i,
    input  logic [HALF-1:0]            b_hi_val_i,
    output logic [NREG-1:0][HALF-1:0]  nx_lo_o,
    output logic [NREG-1:0][HALF-1:0]  nx_hi_o
);

    logic [NREG-1:0][HALF-1:0] lo_q;
    logic [NREG-1:0][HALF-1:0] hi_q;

    for (genvar n = 0; n < NREG; n++) begin : g_half
        // Pick the next value of each half: port A, then port B, else hold.
        always_comb begin
            nx_lo_o[n] = a_lo_we_i[n] ? a_lo_val_i[n] :
                         b_lo_we_i[n] ? b_lo_val_i[n] : lo_q[n];
            nx_hi_o[n] = a_hi_we_i[n] ? a_hi_val_i :
                         b_hi_we_i[n] ? b_hi_val_i : hi_q[n];
        end

        // R8: on a clash, the stored low half comes from port A.
        p_port0_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (a_lo_we_i[n] && b_lo_we_i[n]) |=> (lo_q[n] == $past(a_lo_val_i[n])));

        // R10: with no enable on a half, that half keeps its value.
        p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!a_lo_we_i[n] && !b_lo_we_i[n] && !a_hi_we_i[n] && !b_hi_we_i[n])
            |=> ($stable(lo_q[n]) && $stable(hi_q[n])));
    end

    // Register the merged values; reset clears every half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= nx_lo_o;
            hi_q <= nx_hi_o;
        end
    end

endmodule

// File: rtl/fpr_rd_mux.sv
// Module: one read port. It selects halves from the write-through view
// according to precision and mode.
// Assumes its inputs already include this cycle's writes.
module fpr_rd_mux
    import fpr_pkg::*;
#(
    parameter int unsigned NREG = FPR_NREG,
    parameter int unsigned HALF = FPR_HALF,
    localparam int unsigned SELW = $clog2(NREG)
) (
    input  logic                       wide_mode_i,
    input  logic [SELW-1:0]            sel_i,
    input  logic                       dbl_i,
    input  logic [NREG-1:0][HALF-1:0]  lo_i,
    input  logic [NREG-1:0][HALF-1:0]  hi_i,
    output logic [2*HALF-1:0]          data_o,
    output logic                       bad_o
);

    acc_kind_t       kind;
    logic [SELW-1:0] sel_odd;

    // Form the read word for the classified access.
    always_comb begin
        kind    = fpr_classify(dbl_i, wide_mode_i, sel_i[0]);
        sel_odd = sel_i | SELW'(1);
        bad_o   = (kind == ACC_BAD);
        unique case (kind)
            ACC_LOW:  data_o = {{HALF{1'b0}}, lo_i[sel_i]};
            ACC_WIDE: data_o = {hi_i[sel_i], lo_i[sel_i]};
            ACC_PAIR: data_o = {lo_i[sel_odd], lo_i[sel_i]};
            default:  data_o = '0;
        endcase
    end

endmodule

// File: rtl/fp_regfile.sv
// Module: top of the two-read, two-write floating-point register file.
// The mode input selects wide registers or even/odd pairing. Write port 0
// has priority, and reads see same-cycle writes.
// Assumes the mode input is stable while it is sampled at a clock edge.
module fp_regfile
    import fpr_pkg::*;
#(
    parameter int unsigned NREG = FPR_NREG,
    parameter int unsigned HALF = FPR_HALF,
    localparam int unsigned SELW = $clog2(NREG),
    localparam int unsigned FULL = 2 * HALF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide_mode_i,
    input  logic [SELW-1:0] rd0_sel_i,
    input  logic            rd0_dbl_i,
    output logic [FULL-1:0] rd0_data_o,
    output logic            rd0_bad_o,
    input  logic [SELW-1:0] rd1_sel_i,
    input  logic            rd1_dbl_i,
    output logic [FULL-1:0] rd1_data_o,
    output logic            rd1_bad_o,
    input  logic            wr0_en_i,
    input  logic [SELW-1:0] wr0_sel_i,
    input  logic            wr0_dbl_i,
    input  logic [FULL-1:0] wr0_data_i,
    output logic            wr0_bad_o,
    input  logic            wr1_en_i,
    input  logic [SELW-1:0] wr1_sel_i,
    input  logic            wr1_dbl_i,
    input  logic [FULL-1:0] wr1_data_i,
    output logic            wr1_bad_o
);

    localparam int unsigned NPORT = 2;

    logic [SELW-1:0]           w_sel  [NPORT];
    logic                      w_en   [NPORT];
    logic                      w_dbl  [NPORT];
    logic [FULL-1:0]           w_data [NPORT];
    logic                      w_bad  [NPORT];
    logic [NREG-1:0]           w_lo_we [NPORT];
    logic [NREG-1:0]           w_hi_we [NPORT];
    logic [NREG-1:0][HALF-1:0] w_lo_val [NPORT];
    logic [HALF-1:0]           w_hi_val [NPORT];

    logic [SELW-1:0]           r_sel  [NPORT];
    logic                      r_dbl  [NPORT];
    logic [FULL-1:0]           r_data [NPORT];
    logic                      r_bad  [NPORT];

    logic [NREG-1:0][HALF-1:0] nx_lo;
    logic [NREG-1:0][HALF-1:0] nx_hi;

    // Gather the flat port signals into per-port arrays.
    always_comb begin
        w_en[0] = wr0_en_i;  w_sel[0] = wr0_sel_i;  w_dbl[0] = wr0_dbl_i;  w_data[0] = wr0_data_i;
        w_en[1] = wr1_en_i;  w_sel[1] = wr1_sel_i;  w_dbl[1] = wr1_dbl_i;  w_data[1] = wr1_data_i;
        r_sel[0] = rd0_sel_i; r_dbl[0] = rd0_dbl_i;
        r_sel[1] = rd1_sel_i; r_dbl[1] = rd1_dbl_i;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        fpr_wr_decode #(.NREG(NREG), .HALF(HALF)) i_wdec (
            .clk        (clk),
            .rst_n      (rst_n),
            .wide_mode_i(wide_mode_i),
            .en_i       (w_en[p]),
            .sel_i      (w_sel[p]),
            .dbl_i      (w_dbl[p]),
            .data_i     (w_data[p]),
            .lo_we_o    (w_lo_we[p]),
            .hi_we_o    (w_hi_we[p]),
            .lo_val_o   (w_lo_val[p]),
            .hi_val_o   (w_hi_val[p]),
            .bad_o      (w_bad[p])
        );

        fpr_rd_mux #(.NREG(NREG), .HALF(HALF)) i_rmux (
            .wide_mode_i(wide_mode_i),
            .sel_i      (r_sel[p]),
            .dbl_i      (r_dbl[p]),
            .lo_i       (nx_lo),
            .hi_i       (nx_hi),
            .data_o     (r_data[p]),
            .bad_o      (r_bad[p])
        );
    end

    fpr_store #(.NREG(NREG), .HALF(HALF)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_lo_we_i (w_lo_we[0]),
        .a_hi_we_i (w_hi_we[0]),
        .a_lo_val_i(w_lo_val[0]),
        .a_hi_val_i(w_hi_val[0]),
        .b_lo_we_i (w_lo_we[1]),
        .b_hi_we_i (w_hi_we[1]),
        .b_lo_val_i(w_lo_val[1]),
        .b_hi_val_i(w_hi_val[1]),
        .nx_lo_o   (nx_lo),
        .nx_hi_o   (nx_hi)
    );

    // Drive the flat output ports from the per-port results.
    always_comb begin
        rd0_data_o = r_data[0];
        rd0_bad_o  = r_bad[0];
        rd1_data_o = r_data[1];
        rd1_bad_o  = r_bad[1];
        wr0_bad_o  = w_bad[0];
        wr1_bad_o  = w_bad[1];
    end

    // R9: a single-precision read of the register port 0 writes sees the new word.
    p_write_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en_i && !wr0_dbl_i && !rd0_dbl_i && rd0_sel_i == wr0_sel_i)
        |-> (rd0_data_o == {{HALF{1'b0}}, wr0_data_i[HALF-1:0]}));

endmodule

// File: tb/test_fp_regfile.sv
// Bench: a behavioural model kept as a plain array of 64-bit registers, compared every cycle.
module test_fp_regfile;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wide_mode;
    logic [4:0]  r0s, r1s, w0s, w1s;
    logic        r0d, r1d, w0e, w0d, w1e, w1d;
    logic [63:0] w0v, w1v;
    logic [63:0] rd0_data, rd1_data;
    logic        rd0_bad, rd1_bad, wr0_bad, wr1_bad;

    logic [63:0] mdl [32];
    logic [63:0] nxt [32];
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;
    string       tag_ovr = "";

    always #4 clk = ~clk;

    fp_regfile i_fp_regfile (
        .clk(clk), .rst_n(rst_n), .wide_mode_i(wide_mode),
        .rd0_sel_i(r0s), .rd0_dbl_i(r0d), .rd0_data_o(rd0_data), .rd0_bad_o(rd0_bad),
        .rd1_sel_i(r1s), .rd1_dbl_i(r1d), .rd1_data_o(rd1_data), .rd1_bad_o(rd1_bad),
        .wr0_en_i(w0e), .wr0_sel_i(w0s), .wr0_dbl_i(w0d), .wr0_data_i(w0v), .wr0_bad_o(wr0_bad),
        .wr1_en_i(w1e), .wr1_sel_i(w1s), .wr1_dbl_i(w1d), .wr1_data_i(w1v), .wr1_bad_o(wr1_bad)
    );

    // Expected read from the post-write view (write-through, R9).
    function automatic logic [63:0] mread(logic [4:0] s, logic d, logic m);
        if (!d) return {32'h0, nxt[s][31:0]};
        if (m) return nxt[s];
        if (s[0]) return 64'h0;
        return {nxt[s + 5'd1][31:0], nxt[s][31:0]};
    endfunction

    task automatic mwrite(logic e, logic [4:0] s, logic d, logic m, logic [63:0] v);
        if (!e) return;
        if (!d) nxt[s][31:0] = v[31:0];
        else if (m) nxt[s] = v;
        else if (!s[0]) begin
            nxt[s][31:0]        = v[31:0];
            nxt[s + 5'd1][31:0] = v[63:32];
        end
    endtask

    function automatic string rtag(logic d, logic m, logic [4:0] s);
        if (tag_ovr != "") return tag_ovr;
        if (!d) return "R2";
        if (m) return "R3";
        if (s[0]) return "R5";
        return "R4";
    endfunction

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check outputs, then commit the model after the rising edge.
    task automatic run(logic m, logic [4:0] a0, logic b0, logic [4:0] a1, logic b1,
                       logic e0, logic [4:0] s0, logic d0, logic [63:0] v0,
                       logic e1, logic [4:0] s1, logic d1, logic [63:0] v1);
        logic x0, x1;
        @(negedge clk);
        wide_mode = m; r0s = a0; r0d = b0; r1s = a1; r1d = b1;
        w0e = e0; w0s = s0; w0d = d0; w0v = v0;
        w1e = e1; w1s = s1; w1d = d1; w1v = v1;
        #2;
        nxt = mdl;
        mwrite(e1, s1, d1, m, v1);
        mwrite(e0, s0, d0, m, v0);   // port 0 applied last wins (R8)
        chk(rtag(b0, m, a0), "rd0 data", rd0_data, mread(a0, b0, m));
        chk(rtag(b1, m, a1), "rd1 data", rd1_data, mread(a1, b1, m));
        x0 = b0 && !m && a0[0];
        x1 = b1 && !m && a1[0];
        chk(x0 ? "R5" : "R6", "rd0 bad", {63'h0, rd0_bad}, {63'h0, x0});
        chk(x1 ? "R5" : "R6", "rd1 bad", {63'h0, rd1_bad}, {63'h0, x1});
        x0 = e0 && d0 && !m && s0[0];
        x1 = e1 && d1 && !m && s1[0];
        chk(x0 ? "R5" : "R6", "wr0 bad", {63'h0, wr0_bad}, {63'h0, x0});
        chk(x1 ? "R5" : "R6", "wr1 bad", {63'h0, wr1_bad}, {63'h0, x1});
        @(posedge clk);
        #1;
        mdl = nxt;
    endtask

    task automatic idle_read(logic m, logic [4:0] a0, logic b0, logic [4:0] a1, logic b1);
        run(m, a0, b0, a1, b1, 0, 0, 0, 64'h0, 0, 0, 0, 64'h0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog got running exp finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wide_mode = 1'b1;
        r0s = 0; r1s = 0; r0d = 0; r1d = 0;
        w0e = 0; w0s = 0; w0d = 0; w0v = '0;
        w1e = 0; w1s = 0; w1d = 0; w1v = '0;
        foreach (mdl[i]) mdl[i] = 64'h0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: every register reads zero after reset.
        tag_ovr = "R1";
        for (int i = 0; i < 16; i++) idle_read(1'b1, 5'(2 * i), 1'b1, 5'(2 * i + 1), 1'b1);
        tag_ovr = "";

        // R2 and R9: single write, upper data ignored, read in the same cycle.
        run(0, 5, 0, 5, 1, 1, 5, 0, 64'hAAAA_BBBB_1234_5678, 0, 0, 0, 64'h0);
        // R2: a full 64-bit view shows an untouched upper word.
        idle_read(1, 5, 1, 5, 0);
        // R3: wide-mode double write to an odd register, then readback.
        run(1, 7, 1, 6, 1, 1, 7, 1, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 64'h0);
        // R2: a single write keeps the upper word written above.
        run(1, 7, 1, 7, 0, 1, 7, 0, 64'hFFFF_FFFF_0BAD_F00D, 0, 0, 0, 64'h0);
        // R4: paired write to 8 spreads over the low words of 8 and 9.
        run(0, 8, 1, 9, 0, 1, 8, 1, 64'hCAFE_0009_BEEF_0008, 0, 0, 0, 64'h0);
        idle_read(1, 8, 1, 9, 1);
        // R5: paired write to odd 9 is flagged and dropped; read of odd 9 gives zero.
        run(0, 9, 1, 8, 1, 1, 9, 1, 64'h1111_2222_3333_4444, 0, 0, 0, 64'h0);
        idle_read(1, 9, 1, 10, 1);
        // R6: wide-mode double on an odd register is legal.
        run(1, 9, 1, 3, 1, 1, 3, 1, 64'h5555_6666_7777_8888, 0, 0, 0, 64'h0);
        // R8: both ports write register 3 single-precision; port 0 wins.
        run(0, 3, 0, 4, 0, 1, 3, 0, 64'h0000_0000_AAAA_0000, 1, 3, 0, 64'h0000_0000_BBBB_0000);
        // R8: port 0 writes 11 single, port 1 writes the 10/11 pair: only 11 from port 0.
        run(0, 10, 1, 11, 0, 1, 11, 0, 64'h0000_0000_0000_0B0B, 1, 10, 1, 64'h1A1A_1A1A_2B2B_2B2B);
        idle_read(1, 10, 0, 11, 0);
        // R10: disabled write ports with live data change nothing.
        run(1, 12, 1, 13, 1, 0, 12, 1, 64'hDEAD_DEAD_DEAD_DEAD, 0, 13, 1, 64'hBEEF_BEEF_BEEF_BEEF);
        idle_read(1, 12, 1, 13, 1);
        // R7: two reads and two writes on distinct registers in one cycle.
        run(1, 20, 1, 21, 1, 1, 20, 1, 64'h2020_2020_2020_2020, 1, 21, 1, 64'h2121_2121_2121_2121);

        // Random traffic (R2-R10), with the mode changing and register numbers clustered to force clashes.
        for (int k = 0; k < 4000; k++) begin
            logic [4:0] s [4];
            for (int j = 0; j < 4; j++)
                s[j] = ($urandom % 3 == 0) ? 5'($urandom % 32) : 5'($urandom % 4);
            run(1'($urandom), s[0], 1'($urandom), s[1], 1'($urandom),
                1'($urandom), s[2], 1'($urandom), {$urandom, $urandom},
                1'($urandom), s[3], 1'($urandom), {$urandom, $urandom});
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule